// File: doc/BRIEF.md
# Power-Down Clock-Output and Module-Standby Controller

This unit sits in the power-management corner of a microcontroller-style chip. It holds one control register with a standby bit for each on-chip peripheral and one bit that stops the clock output. Software loads the register through a three-state bus write cycle. The new value takes effect at the end of the third state.

For each peripheral in standby, the unit asserts halt and register-clear and keeps both asserted. It also blocks the peripheral's register writes and returns that peripheral's shared pin to general-purpose port control. The tri-statable system-clock pin follows the stop bit and the operating state:

- In normal and sleep modes the pin carries the clock.
- In software standby the pin is parked high.
- In hardware standby the pin is high-impedance.
- Whenever the stop bit is 1 the pin is high-impedance.

The pin's drive state only changes at a falling clock edge, so no shortened pulse appears on the pin.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While reset is asserted and after its release, every halt and clear output is low and the control register is zero. From the first falling clock edge after release in normal mode, the clock pin is driven.
- R2: A write strobe sampled high on a rising edge while no write cycle is in progress starts a write cycle. The control register takes the strobe's data on the third rising edge after that edge. Bit i (for i below NUM_MOD) is the standby bit of module i, and bit NUM_MOD is the clock-output stop bit.
- R3: A write strobe sampled while a write cycle is in progress, including the commit edge itself, is ignored.
- R4: halt[i] and clr[i] are both high for the whole time standby bit i is 1, and low while it is 0.
- R5: per_wr_en[i] equals per_wr_req[i] while standby bit i is 0, and is 0 while the bit is 1.
- R6: While standby bit i is 0, shared pin i has pin_oe=1 and pin_o=mod_tx[i]. While the bit is 1, pin_oe=port_dir[i] and pin_o=port_dat[i].
- R7: With the stop bit at 1, clk_pin_oe is 0 in every operating state.
- R8: In hardware standby (op_mode=3), clk_pin_oe is 0 whatever the stop bit.
- R9: In software standby (op_mode=2) with the stop bit at 0, clk_pin_oe is 1 and clk_pin_o is constantly 1.
- R10: In normal operation (op_mode=0) or sleep (op_mode=1) with the stop bit at 0, clk_pin_oe is 1 and clk_pin_o follows clk.
- R11: The clock pin's drive state is taken from the stop bit and op_mode sampled at a falling clock edge, and it changes only there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Control-register write strobe |
| bus_wdata | input | NUM_MOD+1 | Write data: standby bits, then the stop bit |
| op_mode | input | 2 | Operating state: 0 normal, 1 sleep, 2 software standby, 3 hardware standby |
| per_wr_req | input | NUM_MOD | Register write request per peripheral |
| mod_tx | input | NUM_MOD | Peripheral output for each shared pin |
| port_dir | input | NUM_MOD | Port direction per shared pin (1 = output) |
| port_dat | input | NUM_MOD | Port output data per shared pin |
| mod_halt | output | NUM_MOD | Peripheral halt |
| mod_clr | output | NUM_MOD | Peripheral synchronous register clear |
| per_wr_en | output | NUM_MOD | Gated peripheral register write enable |
| pin_o | output | NUM_MOD | Shared pin output value |
| pin_oe | output | NUM_MOD | Shared pin output enable |
| clk_pin_o | output | 1 | Clock pin output value |
| clk_pin_oe | output | 1 | Clock pin output enable (0 = high-impedance) |

## Verification
The properties assume that op_mode and all bus and peripheral inputs change only just after a rising edge and stay steady through the following falling edge. The stimulus drives every input one nanosecond after a rising edge, which keeps it inside that assumption. The properties also assume that the register changes only through complete write cycles, which holds because bus_wr is the only path into the register. The bench spaces most writes four edges apart and breaks that spacing only on purpose, to exercise the strobe-while-busy case.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
    typedef enum logic [1:0] {
        PD_RUN    = 2'd0,
        PD_SLEEP  = 2'd1,
        PD_SWSTBY = 2'd2,
        PD_HWSTBY = 2'd3
    } pd_mode_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_T1   = 2'd1,
        WS_T2   = 2'd2,
        WS_T3   = 2'd3
    } wr_phase_e;

    typedef struct packed {
        logic oe;
        logic sel;
    } clkpin_t;
endpackage

// File: rtl/pwrdn_wrseq.sv
module pwrdn_wrseq
    import pwrdn_pkg::*;
#(
    parameter int REG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] cfg,
    output logic             commit
);
    typedef struct packed {
        wr_phase_e        phase;
        logic [REG_W-1:0] hold;
        logic [REG_W-1:0] cfg;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            WS_IDLE: begin
                if (bus_wr) begin
                    seq_d.phase = WS_T1;
                    seq_d.hold  = bus_wdata;
                end
            end
            WS_T1: seq_d.phase = WS_T2;
            WS_T2: seq_d.phase = WS_T3;
            WS_T3: begin
                seq_d.phase = WS_IDLE;
                seq_d.cfg   = seq_q.hold;
            end
            default: seq_d.phase = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: WS_IDLE, hold: '0, cfg: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cfg    = seq_q.cfg;
    assign commit = (seq_q.phase == WS_T3);
endmodule

// File: rtl/pwrdn_modgate.sv
module pwrdn_modgate #(
    parameter int NUM_MOD = 8
) (
    input  logic [NUM_MOD-1:0] stby,
    input  logic [NUM_MOD-1:0] per_wr_req,
    input  logic [NUM_MOD-1:0] mod_tx,
    input  logic [NUM_MOD-1:0] port_dir,
    input  logic [NUM_MOD-1:0] port_dat,
    output logic [NUM_MOD-1:0] mod_halt,
    output logic [NUM_MOD-1:0] mod_clr,
    output logic [NUM_MOD-1:0] per_wr_en,
    output logic [NUM_MOD-1:0] pin_o,
    output logic [NUM_MOD-1:0] pin_oe
);
    for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
        always_comb begin
            mod_halt[i]  = stby[i];
            mod_clr[i]   = stby[i];
            per_wr_en[i] = per_wr_req[i] & ~stby[i];
            if (stby[i]) begin
                pin_o[i]  = port_dat[i];
                pin_oe[i] = port_dir[i];
            end else begin
                pin_o[i]  = mod_tx[i];
                pin_oe[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwrdn_clkpin.sv
module pwrdn_clkpin
    import pwrdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop,
    input  logic [1:0] op_mode,
    output logic       clk_pin_o,
    output logic       clk_pin_oe
);
    clkpin_t pin_d, pin_q;
    pd_mode_e mode;

    assign mode = pd_mode_e'(op_mode);

    always_comb begin
        pin_d = '0;
        if (!stop) begin
            unique case (mode)
                PD_RUN, PD_SLEEP: pin_d = '{oe: 1'b1, sel: 1'b1};
                PD_SWSTBY:        pin_d = '{oe: 1'b1, sel: 1'b0};
                default:          pin_d = '0;
            endcase
        end
    end

    // Captured while the clock is low, so the gate never clips a high phase.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign clk_pin_oe = pin_q.oe;
    assign clk_pin_o  = pin_q.oe & (pin_q.sel ? clk : 1'b1);
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl #(
    parameter int NUM_MOD = 8,
    localparam int REG_W  = NUM_MOD + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic [1:0]         op_mode,
    input  logic [NUM_MOD-1:0] per_wr_req,
    input  logic [NUM_MOD-1:0] mod_tx,
    input  logic [NUM_MOD-1:0] port_dir,
    input  logic [NUM_MOD-1:0] port_dat,
    output logic [NUM_MOD-1:0] mod_halt,
    output logic [NUM_MOD-1:0] mod_clr,
    output logic [NUM_MOD-1:0] per_wr_en,
    output logic [NUM_MOD-1:0] pin_o,
    output logic [NUM_MOD-1:0] pin_oe,
    output logic               clk_pin_o,
    output logic               clk_pin_oe
);
    logic [REG_W-1:0] cfg;
    logic             seq_commit;
    logic             cfg_stop;

    assign cfg_stop = cfg[NUM_MOD];

    pwrdn_wrseq #(.REG_W(REG_W)) i_wrseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cfg       (cfg),
        .commit    (seq_commit)
    );

    pwrdn_modgate #(.NUM_MOD(NUM_MOD)) i_modgate (
        .stby       (cfg[NUM_MOD-1:0]),
        .per_wr_req (per_wr_req),
        .mod_tx     (mod_tx),
        .port_dir   (port_dir),
        .port_dat   (port_dat),
        .mod_halt   (mod_halt),
        .mod_clr    (mod_clr),
        .per_wr_en  (per_wr_en),
        .pin_o      (pin_o),
        .pin_oe     (pin_oe)
    );

    pwrdn_clkpin i_clkpin (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop       (cfg_stop),
        .op_mode    (op_mode),
        .clk_pin_o  (clk_pin_o),
        .clk_pin_oe (clk_pin_oe)
    );
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk #(
    parameter int NUM_MOD = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         op_mode,
    input logic               cfg_stop,
    input logic               seq_commit,
    input logic [NUM_MOD-1:0] mod_halt,
    input logic [NUM_MOD-1:0] mod_clr,
    input logic [NUM_MOD-1:0] per_wr_en,
    input logic [NUM_MOD-1:0] port_dir,
    input logic [NUM_MOD-1:0] pin_oe,
    input logic               clk_pin_o,
    input logic               clk_pin_oe
);
    // R2: standby state moves only on the commit edge of a write cycle
    assert_halt_on_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_halt != $past(mod_halt)) |-> $past(seq_commit));

    // R4: a cleared module is held cleared for the whole standby time
    assert_clr_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mod_clr[0]) || $rose(mod_clr[0])) |-> $past(seq_commit));

    assert_wr_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (per_wr_en & mod_halt) == '0);

    assert_port_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_halt & ~port_dir & pin_oe) == '0);

    assert_stop_hiz_R7: assert property (@(negedge clk) disable iff (!rst_n)
        cfg_stop |=> !clk_pin_oe);

    assert_hw_hiz_R8: assert property (@(negedge clk) disable iff (!rst_n)
        (op_mode == 2'd3) |=> !clk_pin_oe);

    assert_sw_high_R9: assert property (@(negedge clk) disable iff (!rst_n)
        (op_mode == 2'd2 && !cfg_stop) |=> (clk_pin_oe && clk_pin_o));
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk #(.NUM_MOD(NUM_MOD)) i_chk (.*);

// File: tb/test_pwrdn_ctrl.sv
`timescale 1ns/1ps
module test_pwrdn_ctrl;
    localparam int N = 8;
    localparam int W = N + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [1:0]   op_mode = 2'd0;
    logic [N-1:0] per_wr_req = '0, mod_tx = '0, port_dir = '0, port_dat = '0;
    logic [N-1:0] mod_halt, mod_clr, per_wr_en, pin_o, pin_oe;
    logic         clk_pin_o, clk_pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwrdn_ctrl #(.NUM_MOD(N)) i_pwrdn_ctrl (.*);

    // behavioural reference
    int           m_phase = 0;
    logic [W-1:0] m_hold = '0, m_cfg = '0;
    bit           m_oe = 0, m_clk = 0;
    string        m_tag = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_hold = '0; m_cfg = '0;
        end else if (m_phase == 3) begin
            m_cfg = m_hold; m_phase = 0;
        end else if (m_phase != 0) begin
            m_phase = m_phase + 1;
        end else if (bus_wr) begin
            m_phase = 1; m_hold = bus_wdata;
        end
    end

    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_oe = 0; m_clk = 0;
        end else if (clk == 1'b0) begin
            m_oe  = !m_cfg[N] && op_mode != 2'd3;
            m_clk = !m_cfg[N] && op_mode < 2'd2;
            if (m_cfg[N])            m_tag = "R7";
            else if (op_mode == 2'd3) m_tag = "R8";
            else if (op_mode == 2'd2) m_tag = "R9";
            else                     m_tag = "R10";
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input bit clk_high);
        logic [N-1:0] stby, e_o, e_oe;
        stby = m_cfg[N-1:0];
        e_o  = (stby & port_dat) | (~stby & mod_tx);
        e_oe = (stby & port_dir) | ~stby;
        chk(mod_halt == stby, "R4", "halt", 32'(mod_halt), 32'(stby));
        chk(mod_clr == stby, "R4", "clr", 32'(mod_clr), 32'(stby));
        chk(per_wr_en == (per_wr_req & ~stby), "R5", "wr_en", 32'(per_wr_en), 32'(per_wr_req & ~stby));
        chk(pin_oe == e_oe, "R6", "pin_oe", 32'(pin_oe), 32'(e_oe));
        chk(pin_o == e_o, "R6", "pin_o", 32'(pin_o), 32'(e_o));
        chk(clk_pin_oe == m_oe, {m_tag, " R11"}, "clk_pin_oe", 32'(clk_pin_oe), 32'(m_oe));
        if (m_oe)
            chk(clk_pin_o == (m_clk ? clk_high : 1'b1), {m_tag, " R11"}, "clk_pin_o",
                32'(clk_pin_o), 32'(m_clk ? clk_high : 1'b1));
    endtask

    always @(posedge clk) begin
        if (rst_n && !done) begin
            #2 compare_all(1'b1);
            #4 compare_all(1'b0);
        end
    end

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [W-1:0] d);
        @(posedge clk); #1 bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 1'b0;
        @(posedge clk);
        @(posedge clk); #2
        if (d[N-1:0] != m_cfg[N-1:0] || 1'b1)
            chk(mod_halt == m_cfg[N-1:0], "R2", "halt before commit", 32'(mod_halt), 32'(m_cfg[N-1:0]));
        @(posedge clk); #3
        chk(mod_halt == d[N-1:0], "R2", "halt at commit", 32'(mod_halt), 32'(d[N-1:0]));
        chk(i_pwrdn_ctrl.clk_pin_oe == m_oe, "R2", "pin follows", 32'(clk_pin_oe), 32'(m_oe));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        chk(mod_halt == '0 && mod_clr == '0, "R1", "halt/clr in reset", 32'(mod_halt), 0);
        chk(clk_pin_oe == 1'b0, "R1", "pin in reset", 32'(clk_pin_oe), 0);
        rst_n = 1'b1;
        cyc(1);
        #4 chk(clk_pin_oe == 1'b1, "R1", "pin driven after reset", 32'(clk_pin_oe), 1);
        chk(mod_halt == '0, "R1", "halt after reset", 32'(mod_halt), 0);

        // active modules: writes and pins pass
        per_wr_req = 8'hA5; mod_tx = 8'h3C; port_dir = 8'h0F; port_dat = 8'hF0;
        cyc(2);
        per_wr_req = 8'h5A; mod_tx = 8'hC3;
        cyc(2);

        // standby on a few modules
        do_write(9'h005);
        per_wr_req = 8'hFF; port_dat = 8'h55;
        cyc(3);
        do_write(9'h0F0);
        per_wr_req = 8'h0F; port_dir = 8'hF3;
        cyc(3);

        // R3: second strobe inside an active cycle is ignored
        @(posedge clk); #1 bus_wr = 1'b1; bus_wdata = 9'h081;
        @(posedge clk); #1 bus_wr = 1'b0;
        @(posedge clk); #1 bus_wr = 1'b1; bus_wdata = 9'h1FF;
        @(posedge clk); #1 bus_wr = 1'b0;
        cyc(3);
        chk(mod_halt == 8'h81, "R3", "strobe while busy", 32'(mod_halt), 32'h81);
        chk(clk_pin_oe == 1'b1, "R3", "stop bit untouched", 32'(clk_pin_oe), 1);

        // stop bit across all modes
        do_write(9'h100);
        for (int md = 0; md < 4; md++) begin
            op_mode = 2'(md);
            cyc(3);
        end

        // stop cleared, walk modes
        do_write(9'h000);
        for (int md = 3; md >= 0; md--) begin
            op_mode = 2'(md);
            cyc(3);
        end
        op_mode = 2'd2; cyc(2);
        op_mode = 2'd1; cyc(2);
        op_mode = 2'd3; cyc(2);
        op_mode = 2'd0; cyc(2);

        // stop set while in software standby, then release everything
        op_mode = 2'd2;
        do_write(9'h1AA);
        cyc(2);
        do_write(9'h000);
        per_wr_req = 8'hFF; mod_tx = 8'h96;
        cyc(3);

        done = 1;
        #10;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule